// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit holds the fetch program counter of a two-stage in-order core and decides, every cycle, which address is fetched next. The second stage presents the instruction it is executing together with its two register operands. The unit decodes the control-transfer class of that instruction, resolves any branch condition combinationally, and picks one of four candidates: the sequential address, a PC-relative branch target, a region-relative jump target, or a register value.

When the second stage holds a branch, the fetch PC already points at the instruction in the delay slot. That instruction is fetched and then executes whatever the branch decides. All targets are formed from the delay-slot address, which is the current fetch PC. For the two linking jumps, the unit also supplies the return address, which is the word after the delay slot, and raises a strobe. Reset forces the PC to a fixed vector.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high, `pcF` is loaded with 0x00001000 on every rising edge, whatever the other inputs are.
- R2: When `redirect` is low, `pcNext` equals `pcF + 4`. Any opcode outside the control-transfer set below gives `redirect` low. This includes SPECIAL (opcode 0) with a funct other than 8 or 9.
- R3: For opcode 2 (jump) and opcode 3 (jump-and-link), `pcNext` is `{pcF[31:28], instX[25:0], 2'b00}` and `redirect` is high.
- R4: For opcode 0 with funct (`instX[5:0]`) 8 (register jump) or 9 (register jump-and-link), `pcNext` equals `rsVal` and `redirect` is high.
- R5: Opcode 4 is taken when `rsVal == rtVal`. Opcode 5 is taken when they differ.
- R6: Opcode 6 is taken when `rsVal` is zero or its bit 31 is set. Opcode 7 is taken when `rsVal` is non-zero and bit 31 is clear. The value 0x80000000 counts as negative.
- R7: Opcode 1 selects its test from `instX[20:16]`. A value of 0 is taken when bit 31 of `rsVal` is set. A value of 1 is taken when that bit is clear, zero included. Any other value is never taken.
- R8: A taken branch gives `pcNext = pcF + (sign-extended instX[15:0] << 2)` and `redirect` high. A branch that is not taken gives `pcF + 4` and `redirect` low.
- R9: `linkActive` is high only for opcode 3 and for opcode 0 with funct 9. `linkVal` always equals `pcF + 4`.
- R10: Out of reset, `pcF` takes the value `pcNext` had before each rising edge. The instruction fetched at the delay-slot address is therefore never skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instX | input | 32 | Instruction held in the second stage |
| rsVal | input | 32 | Value of register rs |
| rtVal | input | 32 | Value of register rt |
| pcF | output | 32 | Current fetch address |
| pcNext | output | 32 | Address to be fetched next |
| linkVal | output | 32 | Return address for linking jumps |
| linkActive | output | 1 | High when the instruction writes a return address |
| redirect | output | 1 | High when the next fetch leaves the sequential path |

## Verification
The assertions assume that `instX`, `rsVal` and `rtVal` change only away from the rising edge and are stable across it. The bench meets this by driving them at the falling edge. The assertions also assume that the stage-2 instruction is whatever the environment presents, with no valid qualifier. The bench therefore treats every vector as a live instruction, and during reset it deliberately keeps a jump on `instX` to show that reset wins. Register operands are free 32-bit values, so the stimulus covers zero, the most negative value and ordinary positives for each condition.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM  = 6'd1;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_BLEZ    = 6'd6;
  localparam logic [5:0] OP_BGTZ    = 6'd7;
  localparam logic [5:0] FN_JR      = 6'd8;
  localparam logic [5:0] FN_JALR    = 6'd9;
  localparam logic [4:0] RI_LTZ     = 5'd0;
  localparam logic [4:0] RI_GEZ     = 5'd1;

  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_BRANCH = 2'd1,
    PC_JUMP   = 2'd2,
    PC_REG    = 2'd3
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   linkActive;
  } npcStrobes_t;

  typedef struct packed {
    logic eq;
    logic rsZero;
    logic rsNeg;
  } npcFlags_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [4:0]  rtField,
  input  logic [5:0]  funct,
  input  npcFlags_t   flags,
  output npcStrobes_t strobes
);
  always_comb begin
    strobes.pcSel      = PC_SEQ;
    strobes.linkActive = 1'b0;
    case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JR) begin
          strobes.pcSel = PC_REG;
        end else if (funct == FN_JALR) begin
          strobes.pcSel      = PC_REG;
          strobes.linkActive = 1'b1;
        end
      end
      OP_REGIMM: begin
        if (rtField == RI_LTZ && flags.rsNeg) strobes.pcSel = PC_BRANCH;
        if (rtField == RI_GEZ && !flags.rsNeg) strobes.pcSel = PC_BRANCH;
      end
      OP_J: strobes.pcSel = PC_JUMP;
      OP_JAL: begin
        strobes.pcSel      = PC_JUMP;
        strobes.linkActive = 1'b1;
      end
      OP_BEQ:  if (flags.eq) strobes.pcSel = PC_BRANCH;
      OP_BNE:  if (!flags.eq) strobes.pcSel = PC_BRANCH;
      OP_BLEZ: if (flags.rsNeg || flags.rsZero) strobes.pcSel = PC_BRANCH;
      OP_BGTZ: if (!flags.rsNeg && !flags.rsZero) strobes.pcSel = PC_BRANCH;
      default: strobes.pcSel = PC_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_dpath.sv
module npc_dpath
  import npc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [25:0]     instIdx,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  input  npcStrobes_t     strobes,
  output npcFlags_t       flags,
  output logic [XLEN-1:0] pcF,
  output logic [XLEN-1:0] pcNext,
  output logic [XLEN-1:0] linkVal
);
  localparam int SEXT_W   = XLEN - 18;
  localparam int REGION_W = XLEN - 28;

  logic [XLEN-1:0] pcSeq;
  logic [XLEN-1:0] brOffset;
  logic [XLEN-1:0] brTarget;
  logic [XLEN-1:0] jmpTarget;

  assign flags.eq     = (rsVal == rtVal);
  assign flags.rsZero = (rsVal == '0);
  assign flags.rsNeg  = rsVal[XLEN-1];

  assign pcSeq     = pcF + XLEN'(4);
  assign brOffset  = {{SEXT_W{instIdx[15]}}, instIdx[15:0], 2'b00};
  assign brTarget  = pcF + brOffset;
  assign jmpTarget = {pcF[XLEN-1 -: REGION_W], instIdx, 2'b00};
  assign linkVal   = pcSeq;

  always_comb begin
    case (strobes.pcSel)
      PC_BRANCH: pcNext = brTarget;
      PC_JUMP:   pcNext = jmpTarget;
      PC_REG:    pcNext = rsVal;
      default:   pcNext = pcSeq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pcF <= RESET_VEC[XLEN-1:0];
    else     pcF <= pcNext;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instX,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output logic [XLEN-1:0] pcF,
  output logic [XLEN-1:0] pcNext,
  output logic [XLEN-1:0] linkVal,
  output logic            linkActive,
  output logic            redirect
);
  npcStrobes_t strobes;
  npcFlags_t   flags;

  npc_ctrl ctrl_i (
    .opcode  (instX[31:26]),
    .rtField (instX[20:16]),
    .funct   (instX[5:0]),
    .flags   (flags),
    .strobes (strobes)
  );

  npc_dpath #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) dpath_i (
    .clk     (clk),
    .rst     (rst),
    .instIdx (instX[25:0]),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .strobes (strobes),
    .flags   (flags),
    .pcF     (pcF),
    .pcNext  (pcNext),
    .linkVal (linkVal)
  );

  assign linkActive = strobes.linkActive;
  assign redirect   = (strobes.pcSel != PC_SEQ);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     instX,
  input logic [XLEN-1:0] rsVal,
  input logic [XLEN-1:0] rtVal,
  input logic [XLEN-1:0] pcF,
  input logic [XLEN-1:0] pcNext,
  input logic [XLEN-1:0] linkVal,
  input logic            linkActive,
  input logic            redirect
);
  logic [XLEN-1:0] offChk;
  assign offChk = {{(XLEN-18){instX[15]}}, instX[15:0], 2'b00};

  p_reset_vec_r1: assert property (@(posedge clk)
    rst |=> pcF == XLEN'(32'h0000_1000));

  p_seq_path_r2: assert property (@(posedge clk) disable iff (rst)
    !redirect |-> pcNext == pcF + XLEN'(4));

  p_region_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (instX[31:27] == 5'b00001) |-> pcNext == {pcF[XLEN-1:28], instX[25:0], 2'b00});

  p_reg_jump_r4: assert property (@(posedge clk) disable iff (rst)
    (instX[31:26] == 6'd0 && instX[5:1] == 5'b00100) |-> pcNext == rsVal);

  p_beq_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (instX[31:26] == 6'd4 && rsVal == rtVal) |-> pcNext == pcF + offChk);

  p_blez_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (instX[31:26] == 6'd6 && rsVal[XLEN-1]) |-> redirect);

  p_bgez_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (instX[31:26] == 6'd1 && instX[20:16] == 5'd1 && rsVal == '0) |-> redirect);

  p_link_addr_r9: assert property (@(posedge clk) disable iff (rst)
    linkActive |-> (linkVal == pcF + XLEN'(4) && redirect));

  p_pc_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pcF == $past(pcNext));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .instX      (instX),
  .rsVal      (rsVal),
  .rtVal      (rtVal),
  .pcF        (pcF),
  .pcNext     (pcNext),
  .linkVal    (linkVal),
  .linkActive (linkActive),
  .redirect   (redirect)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instX = 32'd0;
  logic [31:0] rsVal = 32'd0;
  logic [31:0] rtVal = 32'd0;
  logic [31:0] pcF, pcNext, linkVal;
  logic        linkActive, redirect;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst(rst), .instX(instX), .rsVal(rsVal), .rtVal(rtVal),
    .pcF(pcF), .pcNext(pcNext), .linkVal(linkVal),
    .linkActive(linkActive), .redirect(redirect)
  );

  typedef struct packed {
    logic [31:0] inst;
    logic [31:0] rs;
    logic [31:0] rt;
    logic        taken;
    logic        link;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h5, 32'h5, 1'b0, 1'b0, 8'd2},              // R2 nop
    '{32'h2402_0001, 32'h0, 32'h0, 1'b0, 1'b0, 8'd2},              // R2 addiu
    '{32'h00A6_1021, 32'h1, 32'h2, 1'b0, 1'b0, 8'd2},              // R2 addu funct
    '{{6'd2, 26'h000_0400}, 32'h0, 32'h0, 1'b1, 1'b0, 8'd3},       // R3 jump
    '{{6'd3, 26'h3FF_FFFF}, 32'h0, 32'h0, 1'b1, 1'b1, 8'd3},       // R3 jal
    '{{6'd0, 5'd5, 15'd0, 6'd8}, 32'h0000_2000, 32'h0, 1'b1, 1'b0, 8'd4},  // R4 jr
    '{{6'd0, 5'd5, 5'd0, 5'd31, 5'd0, 6'd9}, 32'h0000_3000, 32'h0, 1'b1, 1'b1, 8'd4}, // R4 jalr
    '{{6'd4, 5'd1, 5'd2, 16'h0010}, 32'h5, 32'h5, 1'b1, 1'b0, 8'd5},       // R5 beq eq
    '{{6'd4, 5'd1, 5'd2, 16'h0010}, 32'h5, 32'h6, 1'b0, 1'b0, 8'd5},       // R5 beq ne
    '{{6'd5, 5'd1, 5'd2, 16'hFFF0}, 32'h5, 32'h6, 1'b1, 1'b0, 8'd5},       // R5 bne ne
    '{{6'd5, 5'd1, 5'd2, 16'hFFF0}, 32'h7, 32'h7, 1'b0, 1'b0, 8'd5},       // R5 bne eq
    '{{6'd6, 5'd1, 5'd0, 16'h0004}, 32'h0, 32'h0, 1'b1, 1'b0, 8'd6},       // R6 blez zero
    '{{6'd6, 5'd1, 5'd0, 16'h0004}, 32'h8000_0000, 32'h0, 1'b1, 1'b0, 8'd6}, // R6 blez min
    '{{6'd6, 5'd1, 5'd0, 16'h0004}, 32'h1, 32'h0, 1'b0, 1'b0, 8'd6},       // R6 blez pos
    '{{6'd7, 5'd1, 5'd0, 16'h0008}, 32'h0, 32'h0, 1'b0, 1'b0, 8'd6},       // R6 bgtz zero
    '{{6'd7, 5'd1, 5'd0, 16'h0008}, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 8'd6}, // R6 bgtz min
    '{{6'd7, 5'd1, 5'd0, 16'h0008}, 32'h7, 32'h0, 1'b1, 1'b0, 8'd6},       // R6 bgtz pos
    '{{6'd1, 5'd1, 5'd0, 16'h8000}, 32'h8000_0000, 32'h0, 1'b1, 1'b0, 8'd7}, // R7 bltz min
    '{{6'd1, 5'd1, 5'd0, 16'h0020}, 32'h0, 32'h0, 1'b0, 1'b0, 8'd7},       // R7 bltz zero
    '{{6'd1, 5'd1, 5'd1, 16'h0020}, 32'h0, 32'h0, 1'b1, 1'b0, 8'd7},       // R7 bgez zero
    '{{6'd1, 5'd1, 5'd1, 16'h0020}, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 8'd7}, // R7 bgez min
    '{{6'd1, 5'd1, 5'd2, 16'h0020}, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 8'd7}, // R7 other rt
    '{{6'd4, 5'd0, 5'd0, 16'h0000}, 32'h0, 32'h0, 1'b1, 1'b0, 8'd8},       // R8 zero offset
    '{{6'd5, 5'd3, 5'd4, 16'h7FFF}, 32'h1, 32'h2, 1'b1, 1'b0, 8'd8}        // R8 max offset
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] targetOf(input logic [31:0] inst, input logic [31:0] rs,
                                           input logic [31:0] pc);
    if (inst[31:26] == 6'd2 || inst[31:26] == 6'd3)
      return {pc[31:28], inst[25:0], 2'b00};
    if (inst[31:26] == 6'd0)
      return rs;
    return pc + {{14{inst[15]}}, inst[15:0], 2'b00};
  endfunction

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] expPc;
    string tag;
    // R1: reset state with a jump on the input
    instX = {6'd2, 26'h123_4567};
    repeat (3) @(posedge clk);
    #1 check32("R1 pc during reset", pcF, 32'h0000_1000);
    @(negedge clk) rst = 1'b0;
    instX = 32'd0;
    #1 check32("R1 pc held until first free edge", pcF, 32'h0000_1000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instX = VECS[i].inst;
      rsVal = VECS[i].rs;
      rtVal = VECS[i].rt;
      #1;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      expPc = VECS[i].taken ? targetOf(VECS[i].inst, VECS[i].rs, pcF) : pcF + 32'd4;
      check32({tag, " pcNext"}, pcNext, expPc);
      check32({tag, " redirect"}, {31'd0, redirect}, {31'd0, VECS[i].taken});
      check32({tag, " R9 linkActive"}, {31'd0, linkActive}, {31'd0, VECS[i].link});
      check32({tag, " R9 linkVal"}, linkVal, pcF + 32'd4);
      @(posedge clk);
      #1 check32({tag, " R10 pc update"}, pcF, expPc);
    end

    // R3: region bits come from the fetch PC, not the target field
    @(negedge clk);
    instX = {6'd0, 5'd1, 15'd0, 6'd8};
    rsVal = 32'hA000_0100;
    @(posedge clk);
    @(negedge clk);
    instX = {6'd3, 26'h000_0040};
    #1 check32("R3 region keep", pcNext, 32'hA000_0100);
    @(posedge clk);
    #1 check32("R10 after region jump", pcF, 32'hA000_0100);

    // R1: reset mid-run overrides a pending jump
    @(negedge clk);
    rst = 1'b1;
    instX = {6'd2, 26'h0FF_0000};
    @(posedge clk);
    #1 check32("R1 mid-run reset", pcF, 32'h0000_1000);
    @(posedge clk);
    #1 check32("R1 reset holds", pcF, 32'h0000_1000);
    @(negedge clk) rst = 1'b0;
    instX = 32'd0;
    @(posedge clk);
    #1 check32("R2 first step after reset", pcF, 32'h0000_1004);

    done = 1'b1;
    finishRun();
  end
endmodule